// File: doc/BRIEF.md
# Single-Channel Block Mover with Peripheral Pacing

This block is one DMA channel. It copies a run of items between memory and a fixed peripheral data location, and the peripheral paces the copy one item at a time. Software writes a control word, an item count and two base addresses through a small register port, and then sets the enable bit. For each item the channel waits for the peripheral's request. It then reads one word on its bus master port and writes that word to the destination, and after that it returns a one-cycle acknowledge to the peripheral.

The programmed base addresses never change while the channel runs. Private working copies advance instead, and software cannot see them. These copies are reloaded from the programmed values each time the channel is started. A finished block therefore restarts only when software clears enable, writes a fresh count and sets enable again. The address registers do not need to be rewritten. In circular mode the count and the working addresses reload by themselves, and the stream carries on without software action.

Register map on `cfg_addr`: 0 is the control word, 1 is the count, 2 is the peripheral address, 3 is the memory address and 4 is the status word. Control bits are: [0] enable, [1] completion interrupt enable, [2] direction (1 means memory to peripheral), [3] circular, [4] peripheral step, [5] memory step, [6] 16-bit items, [8:7] priority (held and read back only), [9] memory-to-memory.

Top module: `dma_channel`

## Requirements
- R1: After reset the control word, count and status read as zero, neither bus strobe is asserted, and `dack` and `irq` are low.
- R2: When control bit 9 is clear, an item's bus read begins only after `dreq` has been seen high; while `dreq` stays low no bus access happens and the count holds.
- R3: Each item is a read at the source followed by a write of the same word at the destination. With control bit 2 set the source is the memory address and the destination is the peripheral address; with it clear the roles swap. With control bit 6 clear, only the low byte is carried and the upper byte of the write data is zero.
- R4: After each item, a working address whose step bit is set (bit 5 for memory, bit 4 for peripheral) advances by 1 for byte items or by 2 for 16-bit items. A working address whose step bit is clear stays on its base address.
- R5: The count register decrements by one per completed item and reads back the remaining count. The two address registers and the control word read back exactly as written while the channel runs.
- R6: `dack` is high for exactly one cycle, in the cycle right after each completed bus write, and never for two cycles in a row.
- R7: Without circular mode, the channel performs exactly the programmed number of items, sets status bit 0, and then makes no further bus accesses even while `dreq` is held high.
- R8: Setting enable while the count is zero starts nothing. Clearing enable, writing a new count and setting enable again restarts the transfer from the programmed base addresses.
- R9: In circular mode (control bit 3), reaching a zero count sets status bit 0, reloads the count and the working addresses from their programmed values, and the transfer continues.
- R10: While enable is set, writes to the count and address registers are ignored.
- R11: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. `irq` is high exactly when status bit 0 and control bit 1 are both set.
- R12: With control bit 9 set, items run back to back with no `dreq` needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| bus_addr | output | AW | Master address |
| bus_rd | output | 1 | Master read strobe |
| bus_wr | output | 1 | Master write strobe |
| bus_wdata | output | DW | Master write data |
| bus_rdata | input | DW | Master read data |
| bus_ready | input | 1 | Completes the current read or write |
| dreq | input | 1 | Peripheral item request |
| dack | output | 1 | Item acknowledge pulse |
| irq | output | 1 | Completion interrupt |

## Verification
The main transfer is run with five configurations: memory to peripheral with a fixed destination, both addresses stepping, peripheral to memory, 16-bit items, and memory to memory with no request line. Comparing the logged write addresses and data against the bench's own expectations separates direction swaps, wrong step sizes, missing byte masking and a stepping peripheral address. Some runs use a bus that stalls every other cycle, which shows that each phase waits for ready. Directed runs hold the request low, write registers while enabled, restart with and without a fresh count, and let circular mode wrap twice, so that the pacing, ignore, restart and reload rules are each seen at the ports.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int CFG_W  = 32;
    localparam int CTRL_W = 10;

    // Control word, enable at bit 0
    typedef struct packed {
        logic       m2m;     // [9]
        logic [1:0] prio;    // [8:7]
        logic       wide;    // [6]
        logic       mstep;   // [5]
        logic       pstep;   // [4]
        logic       circ;    // [3]
        logic       to_per;  // [2]
        logic       tc_ie;   // [1]
        logic       en;      // [0]
    } ctrl_t;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_COUNT = 3'd1,
        RA_PADDR = 3'd2,
        RA_MADDR = 3'd3,
        RA_STAT  = 3'd4
    } reg_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_ACK,
        ST_DONE
    } xfer_state_t;

    function automatic logic [1:0] addr_step(input logic inc, input logic wide);
        if (!inc) return 2'd0;
        return wide ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             cnt_dec,
    input  logic             cnt_reload,
    input  logic             tc_set,
    output ctrl_t            ctrl,
    output logic             start,
    output logic [AW-1:0]    paddr,
    output logic [AW-1:0]    maddr,
    output logic [CW-1:0]    cnt,
    output logic             tc
);

    reg_sel_t      sel;
    logic          setup_ok;
    logic [CW-1:0] cnt_prog;

    assign sel      = reg_sel_t'(cfg_addr);
    // R10: count and addresses accept writes only while disabled
    assign setup_ok = cfg_wr && !ctrl.en;
    assign start    = cfg_wr && (sel == RA_CTRL) && cfg_wdata[0] && !ctrl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            cnt_prog <= '0;
            cnt      <= '0;
            paddr    <= '0;
            maddr    <= '0;
            tc       <= 1'b0;
        end else begin
            if (cfg_wr && sel == RA_CTRL)
                ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            if (setup_ok && sel == RA_PADDR)
                paddr <= cfg_wdata[AW-1:0];
            if (setup_ok && sel == RA_MADDR)
                maddr <= cfg_wdata[AW-1:0];
            if (setup_ok && sel == RA_COUNT) begin
                cnt_prog <= cfg_wdata[CW-1:0];
                cnt      <= cfg_wdata[CW-1:0];
            end else if (cnt_reload) begin
                cnt <= cnt_prog;              // R9
            end else if (cnt_dec) begin
                cnt <= cnt - 1'b1;            // R5
            end
            if (tc_set)
                tc <= 1'b1;
            else if (cfg_wr && sel == RA_STAT && cfg_wdata[0])
                tc <= 1'b0;                   // R11
        end
    end

    always_comb begin
        case (sel)
            RA_CTRL:  cfg_rdata = CFG_W'(ctrl);
            RA_COUNT: cfg_rdata = CFG_W'(cnt);
            RA_PADDR: cfg_rdata = CFG_W'(paddr);
            RA_MADDR: cfg_rdata = CFG_W'(maddr);
            RA_STAT:  cfg_rdata = CFG_W'(tc);
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic          start,
    input  logic [AW-1:0] paddr,
    input  logic [AW-1:0] maddr,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    input  logic          dreq,
    output logic          dack,
    output logic          cnt_dec,
    output logic          cnt_reload,
    output logic          tc_set
);

    xfer_state_t   state;
    logic [AW-1:0] wp, wm;        // hidden working addresses
    logic [AW-1:0] src, dst;
    logic [DW-1:0] data_q;
    logic          pace_ok;
    logic          last;

    assign src      = ctrl.to_per ? wm : wp;
    assign dst      = ctrl.to_per ? wp : wm;
    assign pace_ok  = ctrl.m2m || dreq;               // R2, R12
    assign last     = (cnt == '0);

    assign bus_rd     = (state == ST_RD);
    assign bus_wr     = (state == ST_WR);
    assign bus_addr   = (state == ST_WR) ? dst : src;
    assign bus_wdata  = data_q;
    assign dack       = (state == ST_ACK);             // R6
    assign cnt_dec    = (state == ST_WR) && bus_ready;
    assign tc_set     = (state == ST_ACK) && last;     // R7
    assign cnt_reload = tc_set && ctrl.circ;           // R9

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            wp     <= '0;
            wm     <= '0;
            data_q <= '0;
        end else if (start) begin
            wp    <= paddr;                            // R8
            wm    <= maddr;
            state <= last ? ST_DONE : ST_WAIT;
        end else if (!ctrl.en) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_WAIT: if (pace_ok) state <= ST_RD;
                ST_RD: if (bus_ready) begin
                    data_q <= ctrl.wide ? bus_rdata
                                        : {{(DW-8){1'b0}}, bus_rdata[7:0]};  // R3
                    state  <= ST_WR;
                end
                ST_WR: if (bus_ready) begin
                    wm    <= wm + AW'(addr_step(ctrl.mstep, ctrl.wide));     // R4
                    wp    <= wp + AW'(addr_step(ctrl.pstep, ctrl.wide));
                    state <= ST_ACK;
                end
                ST_ACK: begin
                    if (last && ctrl.circ) begin
                        wp    <= paddr;
                        wm    <= maddr;
                        state <= ST_WAIT;
                    end else if (last) begin
                        state <= ST_DONE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: state <= state;
            endcase
        end
    end

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready,
    input  logic             dreq,
    output logic             dack,
    output logic             irq
);

    ctrl_t         ctrl_q;
    logic          start;
    logic [AW-1:0] paddr_q, maddr_q;
    logic [CW-1:0] cnt_q;
    logic          tc_q;
    logic          cnt_dec, cnt_reload, tc_set;

    dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cnt_dec    (cnt_dec),
        .cnt_reload (cnt_reload),
        .tc_set     (tc_set),
        .ctrl       (ctrl_q),
        .start      (start),
        .paddr      (paddr_q),
        .maddr      (maddr_q),
        .cnt        (cnt_q),
        .tc         (tc_q)
    );

    dma_xfer_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl_q),
        .start      (start),
        .paddr      (paddr_q),
        .maddr      (maddr_q),
        .cnt        (cnt_q),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ready  (bus_ready),
        .dreq       (dreq),
        .dack       (dack),
        .cnt_dec    (cnt_dec),
        .cnt_reload (cnt_reload),
        .tc_set     (tc_set)
    );

    assign irq = tc_q && ctrl_q.tc_ie;   // R11

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input ctrl_t         ctrl_q,
    input logic [AW-1:0] paddr_q,
    input logic [AW-1:0] maddr_q,
    input logic [CW-1:0] cnt_q,
    input logic          tc_q,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_ready,
    input logic          dreq,
    input logic          dack,
    input logic          irq
);

    a_r2_read_after_req: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_rd) && !ctrl_q.m2m) |-> $past(dreq));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ready) |=> ($past(cnt_q) == cnt_q + 1'b1));

    a_r5_bases_held: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && $past(ctrl_q.en)) |-> ($stable(paddr_q) && $stable(maddr_q)));

    a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
        dack |=> !dack);

    a_r6_ack_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(dack) |-> $past(bus_wr && bus_ready));

    a_r7_done_after_item: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_q) |-> $past(dack));

    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> tc_q);

endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .paddr_q   (paddr_q),
    .maddr_q   (maddr_q),
    .cnt_q     (cnt_q),
    .tc_q      (tc_q),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_ready (bus_ready),
    .dreq      (dreq),
    .dack      (dack),
    .irq       (irq)
);

// File: tb/dma_channel_bench.sv
module dma_channel_bench;

    localparam int AW = 32;
    localparam int DW = 16;
    localparam int NV = 5;
    localparam int LOGN = 512;

    typedef struct packed {
        logic [9:0]  ctrl;
        logic [15:0] cnt;
        logic [31:0] pa;
        logic [31:0] ma;
    } vec_t;

    // ctrl bits: [9]m2m [8:7]prio [6]wide [5]mstep [4]pstep [3]circ [2]to_per [1]ie [0]en
    localparam vec_t VECS [NV] = '{
        '{ctrl: 10'h1A4, cnt: 16'd4, pa: 32'h4000, ma: 32'h10},
        '{ctrl: 10'h034, cnt: 16'd3, pa: 32'h4100, ma: 32'h20},
        '{ctrl: 10'h020, cnt: 16'd5, pa: 32'h4000, ma: 32'h40},
        '{ctrl: 10'h064, cnt: 16'd3, pa: 32'h4000, ma: 32'h60},
        '{ctrl: 10'h274, cnt: 16'd4, pa: 32'hC0,   ma: 32'h80}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_ready;
    logic          dreq = 1'b0;
    logic          dack, irq;

    logic          auto_req = 1'b0;
    logic          stall_en = 1'b0;
    logic          stall_q = 1'b0;
    logic [15:0]   mem [256];
    logic [31:0]   log_a [LOGN];
    logic [15:0]   log_d [LOGN];
    int            nwr = 0;
    int            prd = 0;
    int            ndack = 0;
    int            dbl_dack = 0;
    logic          dack_prev = 1'b0;
    int            n_run = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    dma_channel u_dma_channel (
        .clk, .rst, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata, .bus_ready,
        .dreq, .dack, .irq
    );

    function automatic logic [15:0] mem_init(input logic [7:0] i);
        return {8'hA5 ^ i, i ^ 8'h3C};
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = mem_init(8'(i));

    // Bus and peripheral models
    assign bus_ready = (bus_rd || bus_wr) && !stall_q;
    assign bus_rdata = (bus_addr < 32'd256) ? mem[bus_addr[7:0]] : 16'(16'h7700 + prd);

    always @(posedge clk) begin
        stall_q <= stall_en ? ~stall_q : 1'b0;
        if (dack) dreq <= 1'b0;
        else      dreq <= auto_req;
        if (bus_wr && bus_ready) begin
            if (nwr < LOGN) begin
                log_a[nwr] <= bus_addr;
                log_d[nwr] <= bus_wdata;
            end
            nwr <= nwr + 1;
            if (bus_addr < 32'd256) mem[bus_addr[7:0]] <= bus_wdata;
        end
        if (bus_rd && bus_ready && bus_addr >= 32'd256) prd <= prd + 1;
        if (dack) ndack <= ndack + 1;
        if (dack && dack_prev) dbl_dack <= dbl_dack + 1;
        dack_prev <= dack;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic wait_tc(input string req, input int lim);
        logic [31:0] s;
        s = 0;
        for (int i = 0; i < lim && s[0] !== 1'b1; i++) rd(3'd4, s);
        chk(req, {31'd0, s[0]}, 32'd1);
    endtask

    task automatic run_vector(input int idx);
        vec_t t;
        int bw, bp;
        logic [31:0] v, ms, ps, src, dst;
        logic [15:0] ed;
        t = VECS[idx];
        auto_req = !t.ctrl[9];
        stall_en = (idx % 2 == 1);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'(t.cnt));
        wr(3'd2, t.pa);
        wr(3'd3, t.ma);
        wr(3'd4, 32'd1);
        bw = nwr; bp = prd;
        wr(3'd0, 32'(t.ctrl) | 32'd3);
        wait_tc(t.ctrl[9] ? "R12" : "R7", 600);
        repeat (10) @(negedge clk);
        chk("R7", 32'(nwr - bw), 32'(t.cnt));
        ms = t.ctrl[5] ? (t.ctrl[6] ? 2 : 1) : 0;
        ps = t.ctrl[4] ? (t.ctrl[6] ? 2 : 1) : 0;
        for (int k = 0; k < int'(t.cnt); k++) begin
            if (t.ctrl[2]) begin
                src = t.ma + ms * k; dst = t.pa + ps * k;
            end else begin
                src = t.pa + ps * k; dst = t.ma + ms * k;
            end
            ed = (src < 256) ? mem_init(src[7:0]) : 16'(16'h7700 + bp + k);
            if (!t.ctrl[6]) ed = {8'h00, ed[7:0]};
            chk("R4", log_a[bw + k], dst);
            chk("R3", 32'(log_d[bw + k]), 32'(ed));
        end
        rd(3'd1, v); chk("R5", v, 32'd0);
        rd(3'd2, v); chk("R5", v, t.pa);
        rd(3'd3, v); chk("R5", v, t.ma);
        rd(3'd0, v); chk("R5", v, 32'(t.ctrl) | 32'd3);
        wr(3'd0, 32'(t.ctrl));
        stall_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, v); chk("R1", v, 32'd0);
        rd(3'd1, v); chk("R1", v, 32'd0);
        rd(3'd4, v); chk("R1", v, 32'd0);
        chk("R1", {28'd0, bus_rd, bus_wr, dack, irq}, 32'd0);

        // Vector table: R3, R4, R5, R7, R12
        for (int i = 0; i < NV; i++) run_vector(i);

        // R2 / R10: request gating and ignored writes while enabled
        auto_req = 1'b0;
        wr(3'd0, 32'h24); wr(3'd1, 32'd4); wr(3'd2, 32'h4000); wr(3'd3, 32'h10); wr(3'd4, 32'd1);
        base = nwr;
        wr(3'd0, 32'h27);
        repeat (20) @(negedge clk);
        chk("R2", 32'(nwr - base), 32'd0);
        chk("R2", {31'd0, bus_rd}, 32'd0);
        wr(3'd1, 32'd9); wr(3'd2, 32'h5000); wr(3'd3, 32'h99);
        rd(3'd1, v); chk("R10", v, 32'd4);
        rd(3'd2, v); chk("R10", v, 32'h4000);
        rd(3'd3, v); chk("R10", v, 32'h10);
        auto_req = 1'b1;
        wait_tc("R2", 400);
        chk("R10", log_a[base], 32'h4000);
        chk("R10", 32'(log_d[base]), 32'(mem_init(8'h10) & 16'h00FF));

        // R11: flag and interrupt
        @(negedge clk);
        chk("R11", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'd0);
        rd(3'd4, v); chk("R11", v, 32'd1);
        wr(3'd0, 32'h25);
        @(negedge clk);
        chk("R11", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'd1);
        rd(3'd4, v); chk("R11", v, 32'd0);

        // R8: restart rules
        wr(3'd0, 32'h24);
        base = nwr;
        wr(3'd0, 32'h25);
        repeat (20) @(negedge clk);
        chk("R8", 32'(nwr - base), 32'd0);
        rd(3'd4, v); chk("R8", v, 32'd0);
        wr(3'd0, 32'h24); wr(3'd1, 32'd2);
        base = nwr;
        wr(3'd0, 32'h25);
        wait_tc("R8", 400);
        chk("R8", 32'(nwr - base), 32'd2);
        chk("R8", log_a[base], 32'h4000);
        chk("R8", 32'(log_d[base]), 32'(mem_init(8'h10) & 16'h00FF));
        chk("R8", 32'(log_d[base + 1]), 32'(mem_init(8'h11) & 16'h00FF));

        // R9: circular reload
        wr(3'd0, 32'h24); wr(3'd1, 32'd3); wr(3'd4, 32'd1);
        base = nwr;
        wr(3'd0, 32'h2D);
        for (int i = 0; i < 400 && (nwr - base) < 7; i++) @(negedge clk);
        wr(3'd0, 32'h2C);
        chk("R9", 32'((nwr - base) >= 7), 32'd1);
        for (int k = 0; k < 7; k++)
            chk("R9", 32'(log_d[base + k]), 32'(mem_init(8'(16 + k % 3)) & 16'h00FF));
        rd(3'd4, v); chk("R9", v, 32'd1);
        repeat (3) @(negedge clk);
        n = nwr;
        repeat (10) @(negedge clk);
        chk("R9", 32'(nwr - n), 32'd0);

        // R6: acknowledge pulses
        chk("R6", 32'(dbl_dack), 32'd0);
        chk("R6", 32'(ndack), 32'(nwr));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule